// File: doc/BRIEF.md
# Programmable UART Receive Framer

This block turns an asynchronous serial line into characters. It watches a line that is sampled on every tick of a sampling enable running at sixteen times the bit rate. It checks each start bit at its midpoint, and then samples every later bit at its centre. The character format is chosen at run time from three inputs: a length code for five to eight data bits, a two-bit parity mode and a polarity bit. Data arrives least significant bit first. Unused upper bits of the output byte read as zero.

Each finished character is presented with a one-cycle done strobe. Beside the byte come its own status flags: a framing error, a parity error and a break indication, plus an address/data flag for multi-drop links. A separate one-cycle strobe marks every accepted start bit, so that a downstream buffer can prepare for an incoming character. The format inputs are latched when a start bit is accepted. Changes to them during a character take effect with the next character.

The controller is a state machine with six states. IDLE waits for a low line and moves to START. START waits half a bit. If the line is low it moves to DATA and emits the start strobe; if the line is high it falls back to IDLE. DATA samples one bit per bit time. After the last data bit it moves to PARITY, or straight to STOP when parity is off. PARITY samples one bit and moves to STOP. STOP samples the stop bit and emits the character. A high stop bit returns it to IDLE. A low stop bit sends it to HOLD, which waits for the line to go high before returning to IDLE.

Top module: `uart_rx_framer`

## Requirements
- R1: After reset the done and start strobes are low and the byte, framing error, parity error, break and address flags all read zero.
- R2: A low pulse on the line that ends before the midpoint of the start bit (eight ticks) produces neither a start strobe nor a character.
- R3: Each accepted start bit produces exactly one start strobe, one clock cycle wide, before the character completes.
- R4: Length code 00, 01, 10, 11 selects 5, 6, 7, 8 data bits, received least significant bit first. Output bits at or above the length read zero.
- R5: Parity mode 00 checks parity. With polarity 0 the data bits plus parity bit hold an even count of ones; with polarity 1 an odd count. A mismatch sets the parity error.
- R6: Parity mode 01 expects the parity-position bit to equal the polarity input, and sets the parity error when it differs.
- R7: Parity mode 10 has no parity bit: the stop bit follows the last data bit, and the parity error and address flag stay zero.
- R8: Parity mode 11 reports the parity-position bit on the address flag and never sets the parity error.
- R9: A low stop bit sets the framing error. The block then accepts no new start bit until the line has returned high.
- R10: Break is set when every data bit, the parity bit (if present) and the stop bit are all low. Break always comes with a framing error.
- R11: The format inputs are captured when the start bit is accepted. Changing them later in the same character does not alter that character's result.
- R12: Each character produces one done strobe, one clock cycle wide, at the stop-bit sample, and the byte and flags hold their values until the next done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Sampling enable at sixteen times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data length code |
| cfg_parity_mode | input | 2 | Parity mode: 00 check, 01 forced, 10 none, 11 multi-drop |
| cfg_parity_sel | input | 1 | Parity polarity or forced level |
| start_valid | output | 1 | One-cycle strobe on an accepted start bit |
| rx_done | output | 1 | One-cycle strobe when a character is complete |
| rx_data | output | 8 | Received byte, right aligned |
| frame_err | output | 1 | Stop bit was low |
| parity_err | output | 1 | Parity bit did not match |
| break_det | output | 1 | Whole frame was low |
| addr_flag | output | 1 | Parity-position bit in multi-drop mode |

## Verification
The assertions assume three things about the inputs. The sampling enable is the only pacing source. Each line level is held for a whole number of bit times measured in ticks. A held-low line is eventually released, so that HOLD can exit. The stimulus drives every bit for exactly sixteen ticks, both with the tick high on every cycle and with it high on alternate cycles. It returns the line high for several bit times after each character. It scrambles the format inputs only after the start strobe, so that the latched format remains the one the expected values are computed from.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int LEN_SPAN = DATA_W - MIN_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        PM_CHECK = 2'b00,
        PM_FORCE = 2'b01,
        PM_NONE  = 2'b10,
        PM_ADDR  = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic [1:0] len;
        par_mode_t  mode;
        logic       sel;
    } rx_cfg_t;

endpackage

// File: rtl/uart_rx_line_sync.sv
module uart_rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_os_timer.sv
module uart_rx_os_timer #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic mid_hit,
    output logic bit_hit
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int HALF  = OS_RATE / 2;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == CNT_W'(OS_RATE - 1)) cnt <= '0;
            else                            cnt <= cnt + 1'b1;
        end
    end

    assign mid_hit = tick && (cnt == CNT_W'(HALF - 1));
    assign bit_hit = tick && (cnt == CNT_W'(OS_RATE - 1));

endmodule

// File: rtl/uart_rx_assembler.sv
module uart_rx_assembler
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [1:0]        len_sel,
    output logic [DATA_W-1:0] data_out,
    output logic              par_acc,
    output logic              all_zero
);

    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic              zero_q;
    logic [3:0]        shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b1;
        end else if (clear) begin
            shreg  <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b1;
        end else if (shift_en) begin
            shreg  <= {bit_in, shreg[DATA_W-1:1]};
            par_q  <= par_q ^ bit_in;
            zero_q <= zero_q & ~bit_in;
        end
    end

    // First bit entered at the top; shift down so bit 0 lands at position 0.
    always_comb begin
        shamt    = 4'(LEN_SPAN) - {2'b00, len_sel};
        data_out = shreg >> shamt;
    end

    assign par_acc  = par_q;
    assign all_zero = zero_q;

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_parity_mode,
    input  logic       cfg_parity_sel,
    output logic       start_valid,
    output logic       rx_done,
    output logic [7:0] rx_data,
    output logic       frame_err,
    output logic       parity_err,
    output logic       break_det,
    output logic       addr_flag
);

    rx_state_t         state;
    rx_state_t         state_nxt;
    rx_cfg_t           cfg_q;
    logic              line;
    logic              mid_hit;
    logic              bit_hit;
    logic              timer_clear;
    logic              start_ok;
    logic [2:0]        bit_idx;
    logic [3:0]        nbits;
    logic              last_data;
    logic              par_bit;
    logic              perr_calc;
    logic [DATA_W-1:0] asm_data;
    logic              asm_par;
    logic              asm_zero;

    uart_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_line),
        .q_out (line)
    );

    uart_rx_os_timer #(.OS_RATE(OS_RATE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .clear   (timer_clear),
        .mid_hit (mid_hit),
        .bit_hit (bit_hit)
    );

    uart_rx_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .shift_en ((state == ST_DATA) && bit_hit),
        .bit_in   (line),
        .len_sel  (cfg_q.len),
        .data_out (asm_data),
        .par_acc  (asm_par),
        .all_zero (asm_zero)
    );

    assign start_ok    = (state == ST_START) && mid_hit && !line;
    assign timer_clear = (state == ST_IDLE) || (state == ST_HOLD) ||
                         ((state == ST_START) && mid_hit);
    assign nbits       = 4'(MIN_BITS) + {2'b00, cfg_q.len};
    assign last_data   = ({1'b0, bit_idx} == (nbits - 4'd1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!line) state_nxt = ST_START;
            end
            ST_START: begin
                if (mid_hit) state_nxt = line ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (bit_hit && last_data)
                    state_nxt = (cfg_q.mode == PM_NONE) ? ST_STOP : ST_PARITY;
            end
            ST_PARITY: begin
                if (bit_hit) state_nxt = ST_STOP;
            end
            ST_STOP: begin
                if (bit_hit) state_nxt = line ? ST_IDLE : ST_HOLD;
            end
            ST_HOLD: begin
                if (line) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Parity verdict from the latched format
    always_comb begin
        unique case (cfg_q.mode)
            PM_CHECK: perr_calc = (par_bit != (asm_par ^ cfg_q.sel));
            PM_FORCE: perr_calc = (par_bit != cfg_q.sel);
            PM_NONE:  perr_calc = 1'b0;
            PM_ADDR:  perr_calc = 1'b0;
            default:  perr_calc = 1'b0;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_valid <= 1'b0;
            rx_done     <= 1'b0;
            rx_data     <= '0;
            frame_err   <= 1'b0;
            parity_err  <= 1'b0;
            break_det   <= 1'b0;
            addr_flag   <= 1'b0;
            cfg_q       <= '{len: 2'b00, mode: PM_CHECK, sel: 1'b0};
            bit_idx     <= '0;
            par_bit     <= 1'b0;
        end else begin
            start_valid <= 1'b0;
            rx_done     <= 1'b0;
            if (start_ok) begin
                start_valid <= 1'b1;
                cfg_q       <= '{len: cfg_len, mode: par_mode_t'(cfg_parity_mode),
                                 sel: cfg_parity_sel};
                bit_idx     <= '0;
                par_bit     <= 1'b0;
            end
            if ((state == ST_DATA) && bit_hit) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if ((state == ST_PARITY) && bit_hit) begin
                par_bit <= line;
            end
            if ((state == ST_STOP) && bit_hit) begin
                rx_done    <= 1'b1;
                rx_data    <= asm_data;
                frame_err  <= !line;
                parity_err <= perr_calc;
                addr_flag  <= (cfg_q.mode == PM_ADDR) && par_bit;
                break_det  <= asm_zero && !line &&
                              ((cfg_q.mode == PM_NONE) || !par_bit);
            end
        end
    end

    // Checks on the protocol outputs
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !start_valid);                                         // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);                                                 // R12
    AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(state) == ST_STOP);                                  // R12
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ((16'(rx_data) >> nbits) == 16'd0));                       // R4
    AST_NOPAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && cfg_q.mode == PM_NONE) |-> (!parity_err && !addr_flag));   // R7
    AST_ADDR_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && cfg_q.mode == PM_ADDR) |-> !parity_err);                   // R8
    AST_BREAK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> frame_err);                                              // R10
    AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> !start_valid);                                  // R9
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA || state == ST_PARITY || state == ST_STOP) |=>
            (start_valid || $stable(cfg_q)));                                  // R11

endmodule

// File: tb/uart_rx_framer_bench.sv
module uart_rx_framer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       slow = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_parity_mode = 2'b10;
    logic       cfg_parity_sel = 1'b0;
    logic       start_valid, rx_done, frame_err, parity_err, break_det, addr_flag;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int sv_cnt = 0;
    int sv_double = 0;
    logic sv_prev = 1'b0;
    logic [7:0] cap_data;
    logic cap_fe, cap_pe, cap_brk, cap_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_framer u_uart_rx_framer (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_parity_mode(cfg_parity_mode),
        .cfg_parity_sel(cfg_parity_sel), .start_valid(start_valid),
        .rx_done(rx_done), .rx_data(rx_data), .frame_err(frame_err),
        .parity_err(parity_err), .break_det(break_det), .addr_flag(addr_flag)
    );

    always @(negedge clk) begin
        os_tick <= slow ? ~os_tick : 1'b1;
        if (rst_n) begin
            if (rx_done) begin
                done_cnt <= done_cnt + 1;
                cap_data <= rx_data;
                cap_fe   <= frame_err;
                cap_pe   <= parity_err;
                cap_brk  <= break_det;
                cap_addr <= addr_flag;
            end
            if (start_valid) sv_cnt <= sv_cnt + 1;
            if (start_valid && sv_prev) sv_double <= sv_double + 1;
            sv_prev <= start_valid;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * (slow ? 32 : 16)) @(negedge clk);
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    // Level the sender puts in the parity position
    function automatic logic par_level(input logic [7:0] d, input logic [1:0] len,
                                       input logic [1:0] mode, input logic sel,
                                       input logic flip);
        case (mode)
            2'b00:   return (^(d & len_mask(len))) ^ sel ^ flip;
            2'b01:   return sel ^ flip;
            default: return flip;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                              input logic [1:0] mode, input logic sel,
                              input logic flip, input logic stop_val,
                              input string tag);
        int n = 5 + int'(len);
        logic pb = par_level(d, len, mode, sel, flip);
        logic [7:0] exp_d = d & len_mask(len);
        int d0 = done_cnt;
        int s0 = sv_cnt;
        cfg_len = len; cfg_parity_mode = mode; cfg_parity_sel = sel;
        rx_line = 1'b0;
        wait_bits(1);
        // scramble the format after the start bit has been accepted (R11)
        cfg_len = 2'($urandom); cfg_parity_mode = 2'($urandom); cfg_parity_sel = 1'($urandom);
        for (int i = 0; i < n; i++) begin
            rx_line = d[i];
            wait_bits(1);
        end
        if (mode != 2'b10) begin
            rx_line = pb;
            wait_bits(1);
        end
        rx_line = stop_val;
        wait_bits(stop_val ? 1 : 3);
        rx_line = 1'b1;
        wait_bits(3);
        check(done_cnt == d0 + 1, {tag, " R12 done count"}, done_cnt - d0, 1);
        check(sv_cnt == s0 + 1, {tag, " R3 start count"}, sv_cnt - s0, 1);
        check(cap_data == exp_d, {tag, " R4 R11 data"}, cap_data, exp_d);
        check(cap_fe == !stop_val, {tag, " R9 framing"}, cap_fe, !stop_val);
        check(cap_pe == ((mode == 2'b00 || mode == 2'b01) && flip),
              {tag, " R5 R6 R7 R8 parity error"}, cap_pe,
              (mode == 2'b00 || mode == 2'b01) && flip);
        check(cap_addr == (mode == 2'b11 && pb), {tag, " R8 address flag"},
              cap_addr, mode == 2'b11 && pb);
        check(cap_brk == (exp_d == 0 && !stop_val && (mode == 2'b10 || !pb)),
              {tag, " R10 break"}, cap_brk,
              exp_d == 0 && !stop_val && (mode == 2'b10 || !pb));
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!rx_done && !start_valid, "R1 strobes", {rx_done, start_valid}, 0);
        check(rx_data == 0 && !frame_err && !parity_err && !break_det && !addr_flag,
              "R1 outputs", {rx_data, frame_err, parity_err, break_det, addr_flag}, 0);

        // R2 short glitch
        begin
            int d0 = done_cnt;
            int s0 = sv_cnt;
            rx_line = 1'b0;
            repeat (5) @(negedge clk);
            rx_line = 1'b1;
            wait_bits(3);
            check(sv_cnt == s0, "R2 glitch start", sv_cnt - s0, 0);
            check(done_cnt == d0, "R2 glitch done", done_cnt - d0, 0);
        end

        // Directed corners
        send_frame(8'hFF, 2'b00, 2'b10, 1'b0, 1'b0, 1'b1, "R4 len5");
        send_frame(8'hA5, 2'b01, 2'b10, 1'b0, 1'b0, 1'b1, "R4 len6");
        send_frame(8'h3C, 2'b11, 2'b10, 1'b0, 1'b0, 1'b1, "R7 none");
        send_frame(8'h81, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, "R5 even ok");
        send_frame(8'h81, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1, "R5 odd ok");
        send_frame(8'h07, 2'b10, 2'b00, 1'b0, 1'b1, 1'b1, "R5 even bad");
        send_frame(8'h55, 2'b11, 2'b01, 1'b1, 1'b0, 1'b1, "R6 force1 ok");
        send_frame(8'h55, 2'b11, 2'b01, 1'b0, 1'b1, 1'b1, "R6 force0 bad");
        send_frame(8'h42, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, "R8 addr");
        send_frame(8'h42, 2'b11, 2'b11, 1'b1, 1'b0, 1'b1, "R8 data");
        send_frame(8'h12, 2'b11, 2'b10, 1'b0, 1'b0, 1'b0, "R9 stop low");
        send_frame(8'h00, 2'b11, 2'b00, 1'b0, 1'b0, 1'b0, "R10 break");
        send_frame(8'hE0, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, "R10 break len5");
        send_frame(8'h69, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1, "R11 cfg scramble");

        // Half-rate sampling enable
        slow = 1'b1;
        send_frame(8'hC3, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, "R5 slow");
        send_frame(8'h00, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1, "R8 slow");
        slow = 1'b0;
        wait_bits(1);

        // Constrained random frames
        for (int k = 0; k < 250; k++) begin
            logic [7:0] d  = 8'($urandom);
            logic [1:0] ln = 2'($urandom);
            logic [1:0] md = 2'($urandom);
            logic       sl = 1'($urandom);
            logic       fl = ($urandom_range(0, 5) == 0);
            logic       st = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 9) == 0) d = 8'h00;
            send_frame(d, ln, md, sl, fl, st, "R4 random");
        end

        check(sv_double == 0, "R3 start strobe width", sv_double, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule